// File: doc/BRIEF.md
# Receive Character Queue with Line-Error Tracking

This block buffers received characters between a serial deserializer and the host. Each character is stored with three error marks: framing, parity and break. The head of the queue is shown to the host at all times: the data byte and the three marks of the oldest stored character. A pop strobe, raised when the host reads the receive data register, removes that character.

The block also produces two summary indications for the host's line-status view. The first is a flag that stays set while any character still in the queue carries an error mark. It is kept up by a running count of marked entries, so it drops only when the last marked character has been popped; the host's line-status interrupt is raised from it. The second is a sticky overrun flag. A push into a full queue sets it, and a read of the line-status register clears it.

Top module: `rx_err_fifo`

## Requirements
- R1: After reset the queue is empty, `data_ready_o`, `err_any_o` and `overrun_o` are 0, and every head output is 0.
- R2: Characters leave in the order they were pushed. `data_ready_o` is 1 exactly when at least one character is stored. A push or pop is visible at the outputs from the clock edge that accepts it.
- R3: `head_fe_o`, `head_pe_o` and `head_brk_o` always equal the marks stored with the head character. After a pop they show the marks of the new head.
- R4: While the queue is empty, `head_data_o` and all three head mark outputs are 0.
- R5: `err_any_o` is 1 while at least one stored character has any mark set. It returns to 0 on the edge that pops the last marked character.
- R6: A push while 64 characters are stored and no pop is requested is discarded: the stored characters are left unchanged and `overrun_o` is set.
- R7: `overrun_o` stays set until a cycle with `lsr_rd_i` high clears it. If a discarded push and `lsr_rd_i` fall in the same cycle, `overrun_o` stays set.
- R8: A push and a pop in the same cycle both take effect, including when the queue is full (the push is then accepted and no overrun occurs). The marked-entry tracking stays exact in that cycle.
- R9: A pop while the queue is empty is ignored and changes no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| push_i | input | 1 | Store one character this cycle |
| push_data_i | input | 8 | Received character |
| push_fe_i | input | 1 | Framing error mark of the character |
| push_pe_i | input | 1 | Parity error mark of the character |
| push_brk_i | input | 1 | Break mark of the character |
| pop_i | input | 1 | Remove the head character (receive data read) |
| lsr_rd_i | input | 1 | Line-status read; clears overrun |
| head_data_o | output | 8 | Data of the head character, 0 when empty |
| head_fe_o | output | 1 | Framing mark of the head character |
| head_pe_o | output | 1 | Parity mark of the head character |
| head_brk_o | output | 1 | Break mark of the head character |
| err_any_o | output | 1 | Some stored character carries a mark |
| data_ready_o | output | 1 | Queue is not empty |
| overrun_o | output | 1 | Sticky: a character was dropped on a full queue |

## Verification
The bench places marked characters behind clean ones. This catches a design that takes its summary flag from the head alone, because such a design would drop `err_any_o` while marked entries remain further back. It overfills the queue with a marked character and then drains it. A design that overwrote an entry would show the dropped byte, and one that counted dropped pushes would leave the summary flag stuck high. Same-cycle push and pop are driven on a full queue and on a one-entry queue where both characters are marked, which shows an off-by-one in the marked-entry counter. Overrun is raised and cleared with the line-status read falling on the same cycle as the set.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  localparam int DATA_W = 8;

  typedef struct packed {
    logic              brk;
    logic              pe;
    logic              fe;
    logic [DATA_W-1:0] data;
  } rxq_entry_t;

  function automatic logic entry_has_err(input rxq_entry_t e);
    return e.fe | e.pe | e.brk;
  endfunction
endpackage

// File: rtl/rxq_store.sv
module rxq_store
  import rxq_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_req,
  input  rxq_entry_t    push_entry,
  input  logic          pop_req,
  output rxq_entry_t    head,
  output logic [CW-1:0] count,
  output logic          push_ok,
  output logic          pop_ok,
  output logic          push_drop
);
  rxq_entry_t    mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic          is_full, is_empty;

  function automatic logic [AW-1:0] ptr_next(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  function automatic logic [CW-1:0] count_next(input logic [CW-1:0] c,
                                               input logic inc, input logic dec);
    case ({inc, dec})
      2'b10:   return c + 1'b1;
      2'b01:   return c - 1'b1;
      default: return c;
    endcase
  endfunction

  assign is_full   = (count == CW'(DEPTH));
  assign is_empty  = (count == '0);
  assign pop_ok    = pop_req & ~is_empty;
  assign push_ok   = push_req & (~is_full | pop_ok);
  assign push_drop = push_req & ~push_ok;
  assign head      = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= push_entry;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push_ok) wr_ptr <= ptr_next(wr_ptr);
      if (pop_ok)  rd_ptr <= ptr_next(rd_ptr);
      count <= count_next(count, push_ok, pop_ok);
    end
  end

  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));
  assert_full_drop_keeps_count_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (is_full && push_req && !pop_req) |=> (count == CW'(DEPTH)));
  assert_empty_pop_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (is_empty && pop_req && !push_req) |=> (count == '0));
  assert_push_pop_same_count_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (push_ok && pop_ok) |=> $stable(count));
endmodule

// File: rtl/rxq_err_track.sv
module rxq_err_track #(
  parameter int DEPTH = 64,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          add_err,
  input  logic          rem_err,
  input  logic [CW-1:0] fifo_count,
  output logic          err_any
);
  logic [CW-1:0] err_cnt;

  function automatic logic [CW-1:0] err_next(input logic [CW-1:0] c,
                                             input logic inc, input logic dec);
    return c + CW'(inc) - CW'(dec);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_cnt <= '0;
    else        err_cnt <= err_next(err_cnt, add_err, rem_err);
  end

  assign err_any = (err_cnt != '0);

  assert_errcnt_within_fill_R5: assert property (@(posedge clk) disable iff (!rst_n)
    err_cnt <= fifo_count);
  assert_empty_no_err_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_count == '0) |-> !err_any);
endmodule

// File: rtl/rxq_overrun.sv
module rxq_overrun (
  input  logic clk,
  input  logic rst_n,
  input  logic drop,
  input  logic lsr_rd,
  output logic overrun
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      overrun <= 1'b0;
    else if (drop)   overrun <= 1'b1;
    else if (lsr_rd) overrun <= 1'b0;
  end

  assert_drop_sets_ovr_R6: assert property (@(posedge clk) disable iff (!rst_n)
    drop |=> overrun);
  assert_lsr_clears_ovr_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (lsr_rd && !drop) |=> !overrun);
endmodule

// File: rtl/rx_err_fifo.sv
module rx_err_fifo
  import rxq_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push_i,
  input  logic [DATA_W-1:0] push_data_i,
  input  logic              push_fe_i,
  input  logic              push_pe_i,
  input  logic              push_brk_i,
  input  logic              pop_i,
  input  logic              lsr_rd_i,
  output logic [DATA_W-1:0] head_data_o,
  output logic              head_fe_o,
  output logic              head_pe_o,
  output logic              head_brk_o,
  output logic              err_any_o,
  output logic              data_ready_o,
  output logic              overrun_o
);
  rxq_entry_t    in_entry, head_raw, head_shown;
  logic [CW-1:0] count;
  logic          push_ok, pop_ok, push_drop;
  logic          add_err, rem_err;

  assign in_entry = '{brk: push_brk_i, pe: push_pe_i, fe: push_fe_i, data: push_data_i};

  rxq_store #(.DEPTH(DEPTH)) u_store (
    .clk, .rst_n,
    .push_req(push_i), .push_entry(in_entry), .pop_req(pop_i),
    .head(head_raw), .count(count),
    .push_ok(push_ok), .pop_ok(pop_ok), .push_drop(push_drop)
  );

  assign add_err = push_ok & entry_has_err(in_entry);
  assign rem_err = pop_ok & entry_has_err(head_raw);

  rxq_err_track #(.DEPTH(DEPTH)) u_err (
    .clk, .rst_n,
    .add_err(add_err), .rem_err(rem_err), .fifo_count(count),
    .err_any(err_any_o)
  );

  rxq_overrun u_ovr (
    .clk, .rst_n, .drop(push_drop), .lsr_rd(lsr_rd_i), .overrun(overrun_o)
  );

  assign data_ready_o = (count != '0);
  assign head_shown   = data_ready_o ? head_raw : '0;
  assign head_data_o  = head_shown.data;
  assign head_fe_o    = head_shown.fe;
  assign head_pe_o    = head_shown.pe;
  assign head_brk_o   = head_shown.brk;

  assert_empty_head_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !data_ready_o |-> (head_data_o == '0 && !head_fe_o && !head_pe_o && !head_brk_o));
  assert_head_err_implies_any_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (head_fe_o || head_pe_o || head_brk_o) |-> err_any_o);
endmodule

// File: tb/tb_rx_err_fifo.sv
module tb_rx_err_fifo;
  localparam int DEPTH = 64;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       push_i = 1'b0, pop_i = 1'b0, lsr_rd_i = 1'b0;
  logic [7:0] push_data_i = '0;
  logic       push_fe_i = 1'b0, push_pe_i = 1'b0, push_brk_i = 1'b0;
  logic [7:0] head_data_o;
  logic       head_fe_o, head_pe_o, head_brk_o, err_any_o, data_ready_o, overrun_o;

  int checks = 0;
  int fails  = 0;
  logic [10:0] q[$];
  bit          ovr_m = 1'b0;

  always #4 clk = ~clk;

  rx_err_fifo #(.DEPTH(DEPTH)) dut (.*);

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic monitor(input string tag);
    logic [10:0] h;
    bit anyerr;
    h = (q.size() > 0) ? q[0] : '0;
    anyerr = 1'b0;
    foreach (q[i]) if (q[i][10:8] != 3'b000) anyerr = 1'b1;
    chk(tag, "data_ready", data_ready_o, q.size() > 0);
    chk(tag, "head_data", head_data_o, h[7:0]);
    chk(tag, "head_marks", {head_brk_o, head_pe_o, head_fe_o}, h[10:8]);
    chk(tag, "err_any", err_any_o, anyerr);
    chk(tag, "overrun", overrun_o, ovr_m);
  endtask

  // drive at negedge, model at posedge, monitor at next negedge
  task automatic step(input bit psh, input logic [7:0] d, input logic [2:0] marks,
                      input bit pp, input bit lr, input string tag, input bit mon = 1);
    bit pop_ok, push_ok;
    push_i = psh; push_data_i = d; {push_brk_i, push_pe_i, push_fe_i} = marks;
    pop_i = pp; lsr_rd_i = lr;
    @(posedge clk);
    pop_ok  = pp && q.size() > 0;
    push_ok = psh && (q.size() < DEPTH || pop_ok);
    if (pop_ok) void'(q.pop_front());
    if (push_ok) q.push_back({marks, d});
    if (psh && !push_ok) ovr_m = 1'b1;
    else if (lr) ovr_m = 1'b0;
    @(negedge clk);
    push_i = 1'b0; pop_i = 1'b0; lsr_rd_i = 1'b0;
    if (mon) monitor(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    monitor("R1_reset");
    // R4: empty head reads zero, R9: pop on empty ignored
    step(0, 8'h00, 3'b000, 1, 0, "R9_pop_empty");
    chk("R4", "empty_head", head_data_o, 0);
    // R2: order with clean bytes
    for (int i = 0; i < 5; i++) step(1, 8'h10 + 8'(i), 3'b000, 0, 0, "R2_push");
    for (int i = 0; i < 5; i++) step(0, 8'h00, 3'b000, 1, 0, "R2_pop");
    // R3/R5: marked behind clean
    step(1, 8'hA0, 3'b000, 0, 0, "R5_fill");
    step(1, 8'hA1, 3'b001, 0, 0, "R5_fe_behind");
    step(1, 8'hA2, 3'b000, 0, 0, "R5_fill");
    step(1, 8'hA3, 3'b010, 0, 0, "R5_pe_behind");
    step(1, 8'hA4, 3'b100, 0, 0, "R5_brk_last");
    for (int i = 0; i < 5; i++) step(0, 8'h00, 3'b000, 1, 0, "R3_R5_drain");
    // R8: push and pop together with both marked, one stored
    step(1, 8'hB0, 3'b010, 0, 0, "R8_prep");
    step(1, 8'hB1, 3'b100, 1, 0, "R8_pushpop_marked");
    step(0, 8'h00, 3'b000, 1, 0, "R8_after");
    // R6: fill with clean data, then a marked push is dropped
    for (int i = 0; i < DEPTH; i++) step(1, 8'(i * 3), 3'b000, 0, 0, "R6_fill", 0);
    monitor("R6_full");
    step(1, 8'hEE, 3'b111, 0, 0, "R6_drop");
    step(0, 8'h00, 3'b000, 0, 0, "R7_sticky");
    // R7: drop and lsr read together -> set wins
    step(1, 8'hEF, 3'b001, 0, 1, "R7_set_wins");
    step(0, 8'h00, 3'b000, 0, 1, "R7_clear");
    // R8: full plus push and pop together: push accepted, no overrun
    step(1, 8'h77, 3'b001, 1, 0, "R8_full_pushpop");
    for (int i = 0; i < DEPTH; i++) step(0, 8'h00, 3'b000, 1, 0, "R6_R8_drain");
    step(0, 8'h00, 3'b000, 1, 0, "R9_pop_empty_end");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule